// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block carries out one element-wise string operation (load, store, move, compare or scan) under a repeat mode. Its memory port is a single-port synchronous memory. A start pulse captures the operation, the repeat mode, the element count, the source and destination indices, the direction, the element size, the accumulator and the incoming flags. The block then steps through the elements and updates the count, the indices, the accumulator and the flags. When the sequence ends it pulses done for one cycle. The final register values stay on the outputs until the next start.

The loop tests the count before the first element. It is a "while count is not zero" loop, not a loop that tests at the bottom. A zero count therefore ends at once, with no memory traffic and with every register and flag left as it was loaded. Compare and scan can also end early on the zero flag. Load, store and move ignore that condition. This makes a repeated load with a count of zero or one usable as a conditional load, even from an invalid address.

Top module: `strop_seq`

## Requirements
- R1: When the repeat mode is not none and the count is zero, done rises exactly one cycle after start is sampled. No read or write strobe is issued, and count, indices, accumulator and flags (flags_o bit 0 = zero flag, bit 1 = carry flag) keep the values loaded at start.
- R2: With a repeat mode other than none, every completed element lowers the count by one, and the sequence ends after the element that brings the count to zero.
- R3: Load (op 0), store (op 1) and move (op 2) ignore the equal and not-equal repeat conditions. Under modes 1, 2 and 3 they run until the count is zero.
- R4: Compare (op 3) and scan (op 4) end after any element that leaves the zero flag clear under repeat-while-equal (mode 2), or set under repeat-while-not-equal (mode 3). Otherwise they run until the count is zero.
- R5: Compare sets the flags from memory[source] minus memory[destination], and scan from the accumulator minus memory[destination]. Both operands are zero-extended to the element size. The zero flag means equal and the carry flag means unsigned borrow. Load, store and move never change the flags.
- R6: The element size code 0/1/2/3 selects 1/2/4/8 bytes. After each element the index in use steps by that many bytes, up when the direction input is 0 and down when it is 1. Load steps the source, store and scan step the destination, and move and compare step both.
- R7: The memory port makes at most one access per cycle and never reads and writes in the same cycle. A store element takes 1 cycle, load, move and scan take 2, and compare takes 3 (two reads on successive accesses). Done rises 1 + (sum of element cycles) cycles after start is sampled.
- R8: Repeat mode 0 (none) runs exactly one element whatever the count, and leaves the count unchanged.
- R9: Start is ignored while busy is high, and done is a single-cycle pulse.
- R10: Memory is little-endian. A load sets the accumulator to the zero-extended element. A store writes the low element-size bytes of the accumulator. A move writes the element it read to the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, sampled only while idle |
| op_i | input | 3 | Operation: 0 load, 1 store, 2 move, 3 compare, 4 scan |
| mode_i | input | 2 | Repeat mode: 0 none, 1 always, 2 while equal, 3 while not equal |
| cnt_i | input | CW | Initial element count |
| src_i | input | AW | Initial source byte index |
| dst_i | input | AW | Initial destination byte index |
| dir_i | input | 1 | 0 steps indices up, 1 steps down |
| size_i | input | 2 | Element size code (1, 2, 4, 8 bytes) |
| acc_i | input | 64 | Initial accumulator |
| flags_i | input | 2 | Initial flags (bit 0 zero, bit 1 carry) |
| busy_o | output | 1 | High from start until done has been shown |
| done_o | output | 1 | One-cycle completion pulse |
| cnt_o | output | CW | Current or final count |
| src_o | output | AW | Current or final source index |
| dst_o | output | AW | Current or final destination index |
| acc_o | output | 64 | Current or final accumulator |
| flags_o | output | 2 | Current or final flags |
| mem_rd_o | output | 1 | Read strobe; data returns on mem_rdata_i next cycle |
| mem_wr_o | output | 1 | Write strobe |
| mem_addr_o | output | AW | Byte address of the access |
| mem_size_o | output | 2 | Element size code of the access |
| mem_wdata_o | output | 64 | Write data, element in the low bytes |
| mem_rdata_i | input | 64 | Read data, one cycle after the read strobe |

## Verification
The bench drives start half a cycle before an edge. From that edge it counts edges until done is seen, and compares the count with 1 plus the per-element cycles of the operation: 1 for a zero count, 1 per store element, 2 per load, move or scan element and 3 per compare element. All result registers are final once done is seen, so indices, count, accumulator and flags are read one time unit after that edge. A memory model counts read and write strobes at each edge, which shows that a zero count reaches no address. An early stop is confirmed through both the remaining count and the cycle total.

// File: rtl/strop_pkg.sv
package strop_pkg;
  localparam int DATA_W = 64;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_MOVE  = 3'd2,
    OP_CMPS  = 3'd3,
    OP_SCAS  = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    RM_NONE     = 2'd0,
    RM_ALWAYS   = 2'd1,
    RM_WHILE_EQ = 2'd2,
    RM_WHILE_NE = 2'd3
  } rep_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_ACC0, S_ACC1, S_ACC2, S_DONE
  } st_e;

  typedef struct packed {
    logic cf;
    logic zf;
  } flags_t;

  function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = DATA_W'(64'h0000_0000_0000_00FF);
      2'd1:    size_mask = DATA_W'(64'h0000_0000_0000_FFFF);
      2'd2:    size_mask = DATA_W'(64'h0000_0000_FFFF_FFFF);
      default: size_mask = '1;
    endcase
  endfunction

  function automatic logic [7:0] step_bytes(input logic [1:0] sz);
    step_bytes = 8'd1 << sz;
  endfunction

  function automatic flags_t diff_flags(input logic [DATA_W-1:0] a,
                                        input logic [DATA_W-1:0] b,
                                        input logic [1:0] sz);
    logic [DATA_W-1:0] am, bm;
    am = a & size_mask(sz);
    bm = b & size_mask(sz);
    diff_flags.zf = (am == bm);
    diff_flags.cf = (am < bm);
  endfunction

  function automatic logic uses_src(input op_e op);
    uses_src = (op == OP_LOAD) || (op == OP_MOVE) || (op == OP_CMPS);
  endfunction

  function automatic logic uses_dst(input op_e op);
    uses_dst = (op != OP_LOAD);
  endfunction

  function automatic logic is_cond(input op_e op);
    is_cond = (op == OP_CMPS) || (op == OP_SCAS);
  endfunction
endpackage

// File: rtl/strop_ctrl.sv
module strop_ctrl
  import strop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  op_e  op_i,
  input  rep_e mode_i,
  input  logic cnt_zero_i,
  input  logic cnt_one_i,
  input  logic zf_now_i,
  output st_e  st_o,
  output logic take_o,
  output logic elem_done_o,
  output logic done_o,
  output logic busy_o
);
  st_e st, st_nx;
  logic stop_cond, last_elem;

  assign take_o = start && (st == S_IDLE);

  always_comb begin
    case (st)
      S_ACC0:  elem_done_o = (op_i == OP_STORE);
      S_ACC1:  elem_done_o = (op_i == OP_LOAD) || (op_i == OP_MOVE) || (op_i == OP_SCAS);
      S_ACC2:  elem_done_o = 1'b1;
      default: elem_done_o = 1'b0;
    endcase
  end

  assign stop_cond = is_cond(op_i) &&
                     (((mode_i == RM_WHILE_EQ) && !zf_now_i) ||
                      ((mode_i == RM_WHILE_NE) &&  zf_now_i));
  assign last_elem = (mode_i == RM_NONE) || cnt_one_i || stop_cond;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:  if (take_o) st_nx = S_CHECK;
      S_CHECK: st_nx = ((mode_i != RM_NONE) && cnt_zero_i) ? S_DONE : S_ACC0;
      S_ACC0:  st_nx = elem_done_o ? (last_elem ? S_DONE : S_ACC0) : S_ACC1;
      S_ACC1:  st_nx = elem_done_o ? (last_elem ? S_DONE : S_ACC0) : S_ACC2;
      S_ACC2:  st_nx = last_elem ? S_DONE : S_ACC0;
      S_DONE:  st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= st_nx;
  end

  assign st_o   = st;
  assign done_o = (st == S_DONE);
  assign busy_o = (st != S_IDLE);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R4
  cond_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_done_o && stop_cond) |=> done_o);
endmodule

// File: rtl/strop_idx.sv
module strop_idx #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          adv_i,
  input  logic          src_en_i,
  input  logic          dst_en_i,
  input  logic          dec_en_i,
  input  logic          dir_i,
  input  logic [1:0]    size_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [CW-1:0] cnt_o
);
  logic [AW-1:0] step;
  logic [AW-1:0] src_nx, dst_nx;

  assign step   = AW'(strop_pkg::step_bytes(size_i));
  assign src_nx = dir_i ? (src_o - step) : (src_o + step);
  assign dst_nx = dir_i ? (dst_o - step) : (dst_o + step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_o <= '0;
      dst_o <= '0;
      cnt_o <= '0;
    end else if (load_i) begin
      src_o <= src_i;
      dst_o <= dst_i;
      cnt_o <= cnt_i;
    end else if (adv_i) begin
      if (src_en_i) src_o <= src_nx;
      if (dst_en_i) dst_o <= dst_nx;
      if (dec_en_i) cnt_o <= cnt_o - CW'(1);
    end
  end

  // R2
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && dec_en_i && !load_i) |=> (cnt_o == $past(cnt_o) - CW'(1)));

  // R6
  src_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && src_en_i && !dir_i && !load_i) |=> (src_o - $past(src_o)) == $past(step));
endmodule

// File: rtl/strop_flags.sv
module strop_flags
  import strop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [1:0]        flags_i,
  input  logic              upd_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        size_i,
  output logic              zf_now_o,
  output logic [1:0]        flags_o
);
  flags_t res, cur;

  assign res      = diff_flags(a_i, b_i, size_i);
  assign zf_now_o = res.zf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur <= '0;
    else if (load_i) cur <= flags_t'(flags_i);
    else if (upd_i)  cur <= res;
  end

  assign flags_o = cur;

  // R5
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_i && !load_i) |=> $stable(flags_o));
endmodule

// File: rtl/strop_seq.sv
module strop_seq
  import strop_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op_i,
  input  logic [1:0]        mode_i,
  input  logic [CW-1:0]     cnt_i,
  input  logic [AW-1:0]     src_i,
  input  logic [AW-1:0]     dst_i,
  input  logic              dir_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [1:0]        flags_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CW-1:0]     cnt_o,
  output logic [AW-1:0]     src_o,
  output logic [AW-1:0]     dst_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [1:0]        flags_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  op_e               cfg_op;
  rep_e              cfg_mode;
  logic              cfg_dir;
  logic [1:0]        cfg_size;
  logic [DATA_W-1:0] acc, held, rd_el;
  st_e               st;
  logic              take, elem_done, zf_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_op   <= OP_LOAD;
      cfg_mode <= RM_NONE;
      cfg_dir  <= 1'b0;
      cfg_size <= 2'd0;
    end else if (take) begin
      cfg_op   <= op_e'(op_i);
      cfg_mode <= rep_e'(mode_i);
      cfg_dir  <= dir_i;
      cfg_size <= size_i;
    end
  end

  strop_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .op_i        (cfg_op),
    .mode_i      (cfg_mode),
    .cnt_zero_i  (cnt_o == '0),
    .cnt_one_i   (cnt_o == CW'(1)),
    .zf_now_i    (zf_now),
    .st_o        (st),
    .take_o      (take),
    .elem_done_o (elem_done),
    .done_o      (done_o),
    .busy_o      (busy_o)
  );

  strop_idx #(.AW(AW), .CW(CW)) u_idx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (take),
    .src_i    (src_i),
    .dst_i    (dst_i),
    .cnt_i    (cnt_i),
    .adv_i    (elem_done),
    .src_en_i (uses_src(cfg_op)),
    .dst_en_i (uses_dst(cfg_op)),
    .dec_en_i (cfg_mode != RM_NONE),
    .dir_i    (cfg_dir),
    .size_i   (cfg_size),
    .src_o    (src_o),
    .dst_o    (dst_o),
    .cnt_o    (cnt_o)
  );

  assign rd_el = mem_rdata_i & size_mask(cfg_size);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      held <= '0;
    end else if (take) begin
      acc <= acc_i;
    end else begin
      if (elem_done && cfg_op == OP_LOAD)    acc  <= rd_el;
      if (st == S_ACC1 && cfg_op == OP_CMPS) held <= rd_el;
    end
  end

  strop_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (take),
    .flags_i  (flags_i),
    .upd_i    (elem_done && is_cond(cfg_op)),
    .a_i      ((cfg_op == OP_CMPS) ? held : acc),
    .b_i      (mem_rdata_i),
    .size_i   (cfg_size),
    .zf_now_o (zf_now),
    .flags_o  (flags_o)
  );

  always_comb begin
    mem_rd_o    = 1'b0;
    mem_wr_o    = 1'b0;
    mem_addr_o  = src_o;
    mem_wdata_o = '0;
    case (st)
      S_ACC0: begin
        if (cfg_op == OP_STORE) begin
          mem_wr_o    = 1'b1;
          mem_addr_o  = dst_o;
          mem_wdata_o = acc & size_mask(cfg_size);
        end else begin
          mem_rd_o   = 1'b1;
          mem_addr_o = (cfg_op == OP_SCAS) ? dst_o : src_o;
        end
      end
      S_ACC1: begin
        if (cfg_op == OP_MOVE) begin
          mem_wr_o    = 1'b1;
          mem_addr_o  = dst_o;
          mem_wdata_o = rd_el;
        end else if (cfg_op == OP_CMPS) begin
          mem_rd_o   = 1'b1;
          mem_addr_o = dst_o;
        end
      end
      default: ;
    endcase
  end

  assign mem_size_o = cfg_size;
  assign acc_o      = acc;

  // R1
  zero_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHECK && cfg_mode != RM_NONE && cnt_o == '0) |=> (done_o && !mem_rd_o && !mem_wr_o));

  // R7
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o));

  // R9
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(cfg_op) && $stable(cfg_mode) && $stable(cfg_size)));

  // R8
  none_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_done && cfg_mode == RM_NONE) |=> $stable(cnt_o));

  // R3
  uncond_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_done && !is_cond(cfg_op) && cfg_mode != RM_NONE && cnt_o != CW'(1)) |=> !done_o);
endmodule

// File: tb/strop_seq_tb.sv
module strop_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  mode_i = '0;
  logic [15:0] cnt_i = '0, src_i = '0, dst_i = '0;
  logic        dir_i = 1'b0;
  logic [1:0]  size_i = '0;
  logic [63:0] acc_i = '0;
  logic [1:0]  flags_i = '0;
  logic        busy_o, done_o, mem_rd_o, mem_wr_o;
  logic [15:0] cnt_o, src_o, dst_o, mem_addr_o;
  logic [63:0] acc_o, mem_wdata_o;
  logic [63:0] mem_rdata_i = '0;
  logic [1:0]  flags_o, mem_size_o;

  logic [7:0] mem [256];
  int nchk = 0, nerr = 0, rd_n = 0, wr_n = 0;

  always #4 clk = ~clk;

  strop_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_i(op_i), .mode_i(mode_i),
    .cnt_i(cnt_i), .src_i(src_i), .dst_i(dst_i), .dir_i(dir_i), .size_i(size_i),
    .acc_i(acc_i), .flags_i(flags_i), .busy_o(busy_o), .done_o(done_o),
    .cnt_o(cnt_o), .src_o(src_o), .dst_o(dst_o), .acc_o(acc_o), .flags_o(flags_o),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o),
    .mem_size_o(mem_size_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  function automatic logic [63:0] elem_at(input int a, input int sz);
    logic [63:0] r = '0;
    for (int i = 0; i < (1 << sz); i++) r[i*8 +: 8] = mem[(a + i) & 255];
    return r;
  endfunction

  always @(posedge clk) begin
    if (mem_rd_o) begin
      mem_rdata_i <= elem_at(int'(mem_addr_o), int'(mem_size_o));
      rd_n++;
    end
    if (mem_wr_o) begin
      for (int i = 0; i < (1 << mem_size_o); i++)
        mem[(int'(mem_addr_o) + i) & 255] <= mem_wdata_o[i*8 +: 8];
      wr_n++;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(input int op, input int md, input int cnt, input int src, input int dst,
                     input int dr, input int sz, input logic [63:0] acc, input int fl,
                     output int cyc);
    @(negedge clk);
    op_i = 3'(op); mode_i = 2'(md); cnt_i = 16'(cnt); src_i = 16'(src); dst_i = 16'(dst);
    dir_i = 1'(dr); size_i = 2'(sz); acc_i = acc; flags_i = 2'(fl);
    rd_n = 0; wr_n = 0; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    cyc = 0;
    while (!done_o && cyc < 500) begin
      @(posedge clk); #1; cyc++;
    end
  endtask

  task automatic finish_run();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R9 reset busy", 64'(busy_o), 64'd0);
    chk("R9 reset done", 64'(done_o), 64'd0);
    chk("R1 reset flags", 64'(flags_o), 64'd0);
  endtask

  task automatic t_zero_load();
    int c;
    run(0, 1, 0, 16'hFFF0, 16'h0040, 0, 3, 64'hDEAD_BEEF, 2'b10, c);
    chk("R1 zero cycles", 64'(c), 64'd1);
    chk("R1 zero no read", 64'(rd_n), 64'd0);
    chk("R1 zero no write", 64'(wr_n), 64'd0);
    chk("R1 zero count", 64'(cnt_o), 64'd0);
    chk("R1 zero src", 64'(src_o), 64'hFFF0);
    chk("R1 zero acc", acc_o, 64'hDEAD_BEEF);
    chk("R1 zero flags", 64'(flags_o), 64'd2);
    finish_run();
  endtask

  task automatic t_zero_cmps();
    int c;
    run(3, 2, 0, 16'h20, 16'h30, 0, 0, 64'd0, 2'b11, c);
    chk("R1 zero cmps flags", 64'(flags_o), 64'd3);
    chk("R1 zero cmps reads", 64'(rd_n), 64'd0);
    chk("R1 zero cmps dst", 64'(dst_o), 64'h30);
    finish_run();
  endtask

  task automatic t_store();
    int c;
    for (int i = 0; i < 16; i++) mem[8'h40 + i] = 8'h00;
    run(1, 1, 4, 0, 16'h40, 0, 1, 64'h1122_3344_5566_7788, 0, c);
    chk("R7 store cycles", 64'(c), 64'd5);
    chk("R7 store writes", 64'(wr_n), 64'd4);
    chk("R2 store count", 64'(cnt_o), 64'd0);
    chk("R6 store dst", 64'(dst_o), 64'h48);
    chk("R10 store low byte", 64'(mem[8'h46]), 64'h88);
    chk("R10 store high byte", 64'(mem[8'h47]), 64'h77);
    chk("R10 store untouched", 64'(mem[8'h48]), 64'h00);
    finish_run();
  endtask

  task automatic t_move_down();
    int c;
    for (int i = 0; i < 16; i++) mem[i] = 8'(8'hA0 + i);
    run(2, 1, 3, 16'h0E, 16'h8E, 1, 1, 64'd0, 2'b10, c);
    chk("R7 move cycles", 64'(c), 64'd7);
    chk("R6 move src", 64'(src_o), 64'h08);
    chk("R6 move dst", 64'(dst_o), 64'h88);
    chk("R10 move first", elem_at(16'h8E, 1), 64'hAFAE);
    chk("R10 move last", elem_at(16'h8A, 1), 64'hABAA);
    chk("R5 move flags kept", 64'(flags_o), 64'd2);
    finish_run();
  endtask

  task automatic t_cmps();
    int c;
    for (int i = 0; i < 4; i++) begin mem[8'h20 + i] = 8'(i + 5); mem[8'h30 + i] = 8'(i + 5); end
    run(3, 2, 4, 16'h20, 16'h30, 0, 0, 64'd0, 2'b00, c);
    chk("R7 cmps cycles", 64'(c), 64'd13);
    chk("R2 cmps count", 64'(cnt_o), 64'd0);
    chk("R5 cmps equal flags", 64'(flags_o), 64'd1);
    chk("R7 cmps reads", 64'(rd_n), 64'd8);
    finish_run();
    mem[8'h31] = 8'd9;
    run(3, 2, 4, 16'h20, 16'h30, 0, 0, 64'd0, 2'b00, c);
    chk("R4 repe stop count", 64'(cnt_o), 64'd2);
    chk("R4 repe stop cycles", 64'(c), 64'd7);
    chk("R6 cmps src", 64'(src_o), 64'h22);
    chk("R5 cmps borrow flags", 64'(flags_o), 64'd2);
    finish_run();
  endtask

  task automatic t_scas();
    int c;
    mem[8'h50] = 8'd1; mem[8'h51] = 8'd2; mem[8'h52] = 8'h5A; mem[8'h53] = 8'd4; mem[8'h54] = 8'd5;
    run(4, 3, 5, 0, 16'h50, 0, 0, 64'hFF5A, 2'b10, c);
    chk("R4 repne stop count", 64'(cnt_o), 64'd2);
    chk("R7 scas cycles", 64'(c), 64'd7);
    chk("R6 scas dst", 64'(dst_o), 64'h53);
    chk("R5 scas flags", 64'(flags_o), 64'd1);
    finish_run();
    run(4, 3, 2, 0, 16'h50, 0, 0, 64'h03, 2'b01, c);
    chk("R4 repne full count", 64'(cnt_o), 64'd0);
    chk("R5 scas above flags", 64'(flags_o), 64'd0);
    finish_run();
  endtask

  task automatic t_load();
    int c;
    for (int i = 0; i < 8; i++) mem[8'h60 + i] = 8'(8'h10 * i + 1);
    run(0, 1, 1, 16'h60, 0, 0, 3, 64'd0, 0, c);
    chk("R10 load acc", acc_o, 64'h7161_5141_3121_1101);
    chk("R2 load count", 64'(cnt_o), 64'd0);
    chk("R7 load reads", 64'(rd_n), 64'd1);
    chk("R7 load cycles", 64'(c), 64'd3);
    finish_run();
    run(0, 0, 7, 16'h60, 0, 0, 2, 64'd0, 0, c);
    chk("R8 none count", 64'(cnt_o), 64'd7);
    chk("R8 none src", 64'(src_o), 64'h64);
    chk("R8 none acc", acc_o, 64'h3121_1101);
    finish_run();
    run(0, 3, 3, 16'h60, 0, 0, 0, 64'd0, 2'b11, c);
    chk("R3 load ne reads", 64'(rd_n), 64'd3);
    chk("R3 load ne acc", acc_o, 64'h21);
    chk("R5 load flags kept", 64'(flags_o), 64'd3);
    finish_run();
  endtask

  task automatic t_busy_start();
    int c;
    @(negedge clk);
    op_i = 3'd1; mode_i = 2'd1; cnt_i = 16'd3; dst_i = 16'hC0; dir_i = 1'b0;
    size_i = 2'd0; acc_i = 64'h33; flags_i = 2'd0; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    op_i = 3'd0; cnt_i = 16'd9; dst_i = 16'h10; start = 1'b1;
    @(negedge clk); start = 1'b0;
    c = 1;
    while (!done_o && c < 500) begin @(posedge clk); #1; c++; end
    chk("R9 busy start dst", 64'(dst_o), 64'hC3);
    chk("R9 busy start count", 64'(cnt_o), 64'd0);
    chk("R9 busy start mem", 64'(mem[8'hC2]), 64'h33);
    @(posedge clk); #1;
    chk("R9 done pulse", 64'(done_o), 64'd0);
    chk("R9 idle after", 64'(busy_o), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_zero_load();
    t_zero_cmps();
    t_store();
    t_move_down();
    t_cmps();
    t_scas();
    t_load();
    t_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #400000;
    nchk++; nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule